// File: doc/BRIEF.md
# Configuration-memory error report unloader

This block accepts a 78-bit error report produced by a configuration-memory integrity checker and makes it usable by the rest of the chip in two ways. First, it shifts the captured report out one bit per enabled cycle, most significant bit first, and pulses a done flag once the last bit has left. Second, it decodes the same report into named location fields and into separate frame-based and column-based error classes. It also drives an error pin from the frame syndrome.

A capture is taken only while no shift-out is in progress. The decoded outputs change only on an accepted capture, and they hold until the next accepted capture. When an error cannot be located, because a type code says it is uncorrectable or the frame code is unassigned, the location-valid flag drops and the location fields read as zero. A set check-bits-update error bit latches the error pin high until reset, whatever later reports carry.

Top module: `emr_unloader`

## Requirements
- R1: The report word has this layout: bits 77:62 frame number, 61:60 column double-word index (0 to 3), 59:55 column bit index (0 to 31), 54:52 column type, 51:20 frame syndrome, 19:10 frame double-word index, 9:5 frame bit index, 4:2 frame type, bit 1 spare, bit 0 check-bits-update error. On an accepted capture the location outputs take these fields one cycle later, and they do not change without an accepted capture.
- R2: `frm_class` is 0 for frame type 000, 1 for 001, 2 for 010 or 011, 3 for 111, and 4 (unrecognised) for 100, 101 or 110.
- R3: `col_class` is 0 for column type 000, 1 for 001, 2 for 010 or 011 (same frame), 3 for 100, 101 or 110 (different frames), and 4 for 111.
- R4: `loc_valid` is low, and all five location outputs are zero, when the frame type is 111, 100, 101 or 110, or when the column type is 111. Otherwise `loc_valid` is high and the location outputs carry the report fields.
- R5: While no check-bits-update error has been latched, `err_pin` is high after a capture whose syndrome is nonzero and low after one whose syndrome is zero.
- R6: A captured report with bit 0 set holds `err_pin` high until reset, including across later reports with a zero syndrome.
- R7: After a capture, `ser_out` presents report bit 77 and advances by one bit on each cycle with `shift_en` high, for exactly 78 bits. It holds on cycles with `shift_en` low.
- R8: `shift_done` is high for exactly one cycle, in the cycle after the enabled cycle that consumes bit 0.
- R9: A capture request that arrives while a shift-out is in progress is ignored: decoded outputs and the serial stream are unchanged.
- R10: After reset all outputs are low or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rpt_valid | input | 1 | Capture request for `rpt_word` |
| rpt_word | input | 78 | Parallel error report |
| shift_en | input | 1 | Advance the serial output by one bit |
| ser_out | output | 1 | Serial report bit, MSB first |
| shift_done | output | 1 | One-cycle pulse after the last bit |
| frame_num | output | 16 | Decoded frame number |
| col_dword | output | 2 | Decoded column double-word index |
| col_bit | output | 5 | Decoded column bit index |
| frm_dword | output | 10 | Decoded frame double-word index |
| frm_bit | output | 5 | Decoded frame bit index |
| frm_class | output | 3 | Frame-based error class |
| col_class | output | 3 | Column-based error class |
| loc_valid | output | 1 | Location fields are meaningful |
| err_pin | output | 1 | Error indication |

## Verification
Every decoded output, the class codes, `loc_valid` and `err_pin` are due one cycle after the edge that accepts a capture. The driver pushes the expected item when it raises `rpt_valid`, and the monitor compares just after the following rising edge. `ser_out` shows bit 77 from the cycle after acceptance and then moves one bit per enabled edge. The bench therefore checks bit 77-k at the k-th falling edge of the shift window, and it checks again after a cycle with the enable held low. `shift_done` is checked at the falling edge that follows the 78th enabled edge, and low both one edge before and one edge after.

// File: rtl/emr_unl_pkg.sv
package emr_unl_pkg;
    localparam int FRAME_W = 16;
    localparam int CDW_W   = 2;
    localparam int CBIT_W  = 5;
    localparam int TYPE_W  = 3;
    localparam int SYN_W   = 32;
    localparam int FDW_W   = 10;
    localparam int FBIT_W  = 5;
    localparam int CLS_W   = 3;

    // bit positions, least significant field first
    localparam int CBU_POS    = 0;
    localparam int SPARE_POS  = CBU_POS + 1;
    localparam int FTYPE_LSB  = SPARE_POS + 1;
    localparam int FBIT_LSB   = FTYPE_LSB + TYPE_W;
    localparam int FDW_LSB    = FBIT_LSB + FBIT_W;
    localparam int SYN_LSB    = FDW_LSB + FDW_W;
    localparam int CTYPE_LSB  = SYN_LSB + SYN_W;
    localparam int CBIT_LSB   = CTYPE_LSB + TYPE_W;
    localparam int CDW_LSB    = CBIT_LSB + CBIT_W;
    localparam int FRAME_LSB  = CDW_LSB + CDW_W;
    localparam int RPT_W      = FRAME_LSB + FRAME_W;

    typedef enum logic [CLS_W-1:0] {
        FC_NONE    = 3'd0,
        FC_SINGLE  = 3'd1,
        FC_DADJ    = 3'd2,
        FC_UNCORR  = 3'd3,
        FC_UNKNOWN = 3'd4
    } frm_cls_e;

    typedef enum logic [CLS_W-1:0] {
        CC_NONE       = 3'd0,
        CC_SINGLE     = 3'd1,
        CC_DADJ_SAME  = 3'd2,
        CC_DADJ_CROSS = 3'd3,
        CC_UNCORR     = 3'd4
    } col_cls_e;

    function automatic frm_cls_e frm_classify(input logic [TYPE_W-1:0] t);
        frm_cls_e r;
        casez (t)
            3'b000:  r = FC_NONE;
            3'b001:  r = FC_SINGLE;
            3'b01?:  r = FC_DADJ;
            3'b111:  r = FC_UNCORR;
            default: r = FC_UNKNOWN;
        endcase
        return r;
    endfunction

    function automatic col_cls_e col_classify(input logic [TYPE_W-1:0] t);
        col_cls_e r;
        casez (t)
            3'b000:  r = CC_NONE;
            3'b001:  r = CC_SINGLE;
            3'b01?:  r = CC_DADJ_SAME;
            3'b111:  r = CC_UNCORR;
            default: r = CC_DADJ_CROSS;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/emr_shifter.sv
module emr_shifter #(
    parameter int LEN = 78
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [LEN-1:0] load_word,
    input  logic           shift_en,
    output logic           ser_out,
    output logic           busy,
    output logic           done
);
    localparam int CNT_W = $clog2(LEN);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LEN - 1);

    typedef struct packed {
        logic [LEN-1:0]   sreg;
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             done;
    } shf_st_t;

    shf_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (load) begin
            st_d.sreg = load_word;
            st_d.cnt  = '0;
            st_d.busy = 1'b1;
        end else if (st_q.busy && shift_en) begin
            st_d.sreg = {st_q.sreg[LEN-2:0], 1'b0};
            if (st_q.cnt == LAST) begin
                st_d.cnt  = '0;
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ser_out = st_q.sreg[LEN-1];
    assign busy    = st_q.busy;
    assign done    = st_q.done;
endmodule

// File: rtl/emr_decoder.sv
module emr_decoder
    import emr_unl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [FRAME_W-1:0]  in_frame,
    input  logic [CDW_W-1:0]    in_cdw,
    input  logic [CBIT_W-1:0]   in_cbit,
    input  logic [TYPE_W-1:0]   in_ctype,
    input  logic [FDW_W-1:0]    in_fdw,
    input  logic [FBIT_W-1:0]   in_fbit,
    input  logic [TYPE_W-1:0]   in_ftype,
    output logic [FRAME_W-1:0]  frame_num,
    output logic [CDW_W-1:0]    col_dword,
    output logic [CBIT_W-1:0]   col_bit,
    output logic [FDW_W-1:0]    frm_dword,
    output logic [FBIT_W-1:0]   frm_bit,
    output frm_cls_e            frm_cls,
    output col_cls_e            col_cls,
    output logic                loc_ok
);
    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [CDW_W-1:0]   cdw;
        logic [CBIT_W-1:0]  cbit;
        logic [FDW_W-1:0]   fdw;
        logic [FBIT_W-1:0]  fbit;
        frm_cls_e           fcls;
        col_cls_e           ccls;
        logic               ok;
    } dec_st_t;

    dec_st_t  st_d, st_q;
    frm_cls_e fc_new;
    col_cls_e cc_new;
    logic     ok_new;

    assign fc_new = frm_classify(in_ftype);
    assign cc_new = col_classify(in_ctype);
    assign ok_new = (fc_new != FC_UNCORR) && (fc_new != FC_UNKNOWN)
                 && (cc_new != CC_UNCORR);

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.fcls  = fc_new;
            st_d.ccls  = cc_new;
            st_d.ok    = ok_new;
            st_d.frame = ok_new ? in_frame : '0;
            st_d.cdw   = ok_new ? in_cdw   : '0;
            st_d.cbit  = ok_new ? in_cbit  : '0;
            st_d.fdw   = ok_new ? in_fdw   : '0;
            st_d.fbit  = ok_new ? in_fbit  : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame_num = st_q.frame;
    assign col_dword = st_q.cdw;
    assign col_bit   = st_q.cbit;
    assign frm_dword = st_q.fdw;
    assign frm_bit   = st_q.fbit;
    assign frm_cls   = st_q.fcls;
    assign col_cls   = st_q.ccls;
    assign loc_ok    = st_q.ok;
endmodule

// File: rtl/emr_err_flag.sv
module emr_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic syn_nz,
    input  logic cbu_err,
    output logic err_pin,
    output logic sticky
);
    typedef struct packed {
        logic sticky;
        logic err;
    } err_st_t;

    err_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.sticky = st_q.sticky | cbu_err;
            st_d.err    = st_d.sticky | syn_nz;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_pin = st_q.err;
    assign sticky  = st_q.sticky;
endmodule

// File: rtl/emr_unloader.sv
module emr_unloader
    import emr_unl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rpt_valid,
    input  logic [RPT_W-1:0]   rpt_word,
    input  logic               shift_en,
    output logic               ser_out,
    output logic               shift_done,
    output logic [FRAME_W-1:0] frame_num,
    output logic [CDW_W-1:0]   col_dword,
    output logic [CBIT_W-1:0]  col_bit,
    output logic [FDW_W-1:0]   frm_dword,
    output logic [FBIT_W-1:0]  frm_bit,
    output logic [CLS_W-1:0]   frm_class,
    output logic [CLS_W-1:0]   col_class,
    output logic               loc_valid,
    output logic               err_pin
);
    logic     shift_busy;
    logic     accept;
    logic     err_sticky;
    frm_cls_e fcls;
    col_cls_e ccls;

    // a request is taken only when no shift-out is running
    assign accept = rpt_valid & ~shift_busy;

    emr_shifter #(.LEN(RPT_W)) shf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_word (rpt_word),
        .shift_en  (shift_en),
        .ser_out   (ser_out),
        .busy      (shift_busy),
        .done      (shift_done)
    );

    emr_decoder dec_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .in_frame  (rpt_word[FRAME_LSB +: FRAME_W]),
        .in_cdw    (rpt_word[CDW_LSB   +: CDW_W]),
        .in_cbit   (rpt_word[CBIT_LSB  +: CBIT_W]),
        .in_ctype  (rpt_word[CTYPE_LSB +: TYPE_W]),
        .in_fdw    (rpt_word[FDW_LSB   +: FDW_W]),
        .in_fbit   (rpt_word[FBIT_LSB  +: FBIT_W]),
        .in_ftype  (rpt_word[FTYPE_LSB +: TYPE_W]),
        .frame_num (frame_num),
        .col_dword (col_dword),
        .col_bit   (col_bit),
        .frm_dword (frm_dword),
        .frm_bit   (frm_bit),
        .frm_cls   (fcls),
        .col_cls   (ccls),
        .loc_ok    (loc_valid)
    );

    emr_err_flag err_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .syn_nz  (|rpt_word[SYN_LSB +: SYN_W]),
        .cbu_err (rpt_word[CBU_POS]),
        .err_pin (err_pin),
        .sticky  (err_sticky)
    );

    assign frm_class = fcls;
    assign col_class = ccls;
endmodule

// File: rtl/emr_unloader_chk.sv
module emr_unloader_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rpt_valid,
    input logic        rpt_msb,
    input logic        accept,
    input logic        busy,
    input logic        ser_out,
    input logic        shift_done,
    input logic [15:0] frame_num,
    input logic [2:0]  frm_class,
    input logic [2:0]  col_class,
    input logic        loc_valid,
    input logic        err_pin,
    input logic        sticky
);
    AST_HOLD_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(frame_num)); // R1

    AST_CLASS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_class <= 3'd4) && (col_class <= 3'd4)); // R2

    AST_LOC_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_class == 3'd3 || frm_class == 3'd4 || col_class == 3'd4) |-> !loc_valid); // R4

    AST_STICKY_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        sticky |-> err_pin); // R6

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        sticky |=> sticky); // R6

    AST_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (ser_out == $past(rpt_msb))); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_done |=> !shift_done); // R8

    AST_DONE_END: assert property (@(posedge clk) disable iff (!rst_n)
        shift_done |-> (!busy && $past(busy))); // R8

    AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && busy) |=> $stable(frame_num)); // R9
endmodule

bind emr_unloader emr_unloader_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rpt_valid  (rpt_valid),
    .rpt_msb    (rpt_word[77]),
    .accept     (accept),
    .busy       (shift_busy),
    .ser_out    (ser_out),
    .shift_done (shift_done),
    .frame_num  (frame_num),
    .frm_class  (frm_class),
    .col_class  (col_class),
    .loc_valid  (loc_valid),
    .err_pin    (err_pin),
    .sticky     (err_sticky)
);

// File: tb/emr_unloader_tb.sv
`timescale 1ns/1ps
module emr_unloader_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rpt_valid = 1'b0;
    logic [77:0] rpt_word = '0;
    logic        shift_en = 1'b0;
    logic        ser_out, shift_done, loc_valid, err_pin;
    logic [15:0] frame_num;
    logic [1:0]  col_dword;
    logic [4:0]  col_bit, frm_bit;
    logic [9:0]  frm_dword;
    logic [2:0]  frm_class, col_class;

    int checks = 0;
    int errors = 0;
    logic mdl_sticky = 1'b0;

    always #2.5 clk = ~clk;

    emr_unloader dut_i (
        .clk(clk), .rst_n(rst_n), .rpt_valid(rpt_valid), .rpt_word(rpt_word),
        .shift_en(shift_en), .ser_out(ser_out), .shift_done(shift_done),
        .frame_num(frame_num), .col_dword(col_dword), .col_bit(col_bit),
        .frm_dword(frm_dword), .frm_bit(frm_bit), .frm_class(frm_class),
        .col_class(col_class), .loc_valid(loc_valid), .err_pin(err_pin)
    );

    typedef struct {
        logic [15:0] frame;
        logic [1:0]  cdw;
        logic [4:0]  cbit;
        logic [9:0]  fdw;
        logic [4:0]  fbit;
        logic [2:0]  fc;
        logic [2:0]  cc;
        logic        lv;
        logic        err;
        logic        stk;
    } exp_t;

    exp_t exp_q[$];
    exp_t last_exp;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, expv);
        end
    endtask

    function automatic logic [77:0] mk(input logic [15:0] fr, input logic [1:0] cdw,
        input logic [4:0] cb, input logic [2:0] ct, input logic [31:0] syn,
        input logic [9:0] fdw, input logic [4:0] fb, input logic [2:0] ft, input logic cbu);
        return {fr, cdw, cb, ct, syn, fdw, fb, ft, 1'b0, cbu};
    endfunction

    // R2 class codes
    function automatic logic [2:0] m_frm(input logic [2:0] t);
        if (t == 3'b000) return 3'd0;
        if (t == 3'b001) return 3'd1;
        if (t[2:1] == 2'b01) return 3'd2;
        if (t == 3'b111) return 3'd3;
        return 3'd4;
    endfunction

    // R3 class codes
    function automatic logic [2:0] m_col(input logic [2:0] t);
        if (t == 3'b000) return 3'd0;
        if (t == 3'b001) return 3'd1;
        if (t[2:1] == 2'b01) return 3'd2;
        if (t == 3'b111) return 3'd4;
        return 3'd3;
    endfunction

    function automatic exp_t model(input logic [77:0] w, input logic stk_in);
        exp_t e;
        logic [2:0] ft, ct;
        ft = w[4:2];
        ct = w[54:52];
        e.fc  = m_frm(ft);
        e.cc  = m_col(ct);
        e.lv  = !(ft == 3'b111 || ft == 3'b100 || ft == 3'b101 || ft == 3'b110 || ct == 3'b111);
        e.frame = e.lv ? w[77:62] : '0;
        e.cdw   = e.lv ? w[61:60] : '0;
        e.cbit  = e.lv ? w[59:55] : '0;
        e.fdw   = e.lv ? w[19:10] : '0;
        e.fbit  = e.lv ? w[9:5]   : '0;
        e.stk = stk_in | w[0];
        e.err = e.stk | (w[51:20] != 32'd0);
        return e;
    endfunction

    // monitor: compares the item due one cycle after an accepted capture
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(frame_num == e.frame, "R1 frame", 32'(frame_num), 32'(e.frame));
                chk(col_dword == e.cdw,   "R1 col_dword", 32'(col_dword), 32'(e.cdw));
                chk(col_bit == e.cbit,    "R1 col_bit", 32'(col_bit), 32'(e.cbit));
                chk(frm_dword == e.fdw,   "R1 frm_dword", 32'(frm_dword), 32'(e.fdw));
                chk(frm_bit == e.fbit,    "R1 frm_bit", 32'(frm_bit), 32'(e.fbit));
                chk(frm_class == e.fc,    "R2 frm_class", 32'(frm_class), 32'(e.fc));
                chk(col_class == e.cc,    "R3 col_class", 32'(col_class), 32'(e.cc));
                chk(loc_valid == e.lv,    "R4 loc_valid", 32'(loc_valid), 32'(e.lv));
                if (e.stk) chk(err_pin == e.err, "R6 err_pin", 32'(err_pin), 32'(e.err));
                else       chk(err_pin == e.err, "R5 err_pin", 32'(err_pin), 32'(e.err));
            end
        end
    end

    // driver: capture one report, then shift it out with bit checks
    task automatic send(input logic [77:0] w, input int gap_at, input int intrude_at);
        exp_t e;
        @(negedge clk);
        rpt_word  = w;
        rpt_valid = 1'b1;
        shift_en  = 1'b0;
        e = model(w, mdl_sticky);
        mdl_sticky = e.stk;
        last_exp = e;
        exp_q.push_back(e);
        @(negedge clk);
        rpt_valid = 1'b0;
        for (int i = 0; i < 78; i++) begin
            if (i == intrude_at + 1) begin
                rpt_valid = 1'b0;
                chk(frame_num == last_exp.frame, "R9 frame held", 32'(frame_num), 32'(last_exp.frame));
                chk(frm_class == last_exp.fc, "R9 class held", 32'(frm_class), 32'(last_exp.fc));
            end
            chk(ser_out == w[77-i], "R7 ser_out", 32'(ser_out), 32'(w[77-i]));
            chk(shift_done == 1'b0, "R8 early done", 32'(shift_done), 32'd0);
            if (i == gap_at) begin
                shift_en = 1'b0;
                @(negedge clk);
                chk(ser_out == w[77-i], "R7 hold w/o enable", 32'(ser_out), 32'(w[77-i]));
            end
            if (i == intrude_at) begin
                rpt_valid = 1'b1;
                rpt_word  = ~w;
            end
            shift_en = 1'b1;
            @(negedge clk);
        end
        shift_en  = 1'b0;
        rpt_valid = 1'b0;
        chk(shift_done == 1'b1, "R8 done", 32'(shift_done), 32'd1);
        @(negedge clk);
        chk(shift_done == 1'b0, "R8 done width", 32'(shift_done), 32'd0);
        chk(ser_out == 1'b0, "R7 end of stream", 32'(ser_out), 32'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rpt_valid = 1'b0;
        shift_en = 1'b0;
        mdl_sticky = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R10 reset state
        chk(ser_out == 0 && shift_done == 0, "R10 serial", {30'd0, ser_out, shift_done}, 32'd0);
        chk(frame_num == 0 && col_dword == 0 && col_bit == 0 && frm_dword == 0 && frm_bit == 0,
            "R10 location", 32'(frame_num), 32'd0);
        chk(frm_class == 0 && col_class == 0, "R10 classes", {26'd0, frm_class, col_class}, 32'd0);
        chk(loc_valid == 0 && err_pin == 0, "R10 flags", {30'd0, loc_valid, err_pin}, 32'd0);

        // R2 R3 R4 R5: every frame/column type pair
        for (int fi = 0; fi < 8; fi++) begin
            for (int ci = 0; ci < 8; ci++) begin
                send(mk(16'(16'h1000 + fi * 8 + ci), 2'(ci), 5'(fi * 4 + ci), 3'(ci),
                        32'(fi * ci), 10'(fi * 100 + ci), 5'(31 - ci), 3'(fi), 1'b0),
                     (ci == 3) ? 10 : -1, (fi == 2) ? 40 : -1);
            end
        end

        // R1 boundary field values
        send(mk(16'hFFFF, 2'd3, 5'd31, 3'b001, 32'h8000_0000, 10'h3FF, 5'd31, 3'b001, 1'b0), 77, 0);
        send(mk(16'h0001, 2'd0, 5'd0, 3'b000, 32'h0, 10'd0, 5'd0, 3'b000, 1'b0), 0, 76);

        // R6 sticky check-bits-update error
        send(mk(16'h0ABC, 2'd1, 5'd7, 3'b000, 32'h0, 10'd5, 5'd2, 3'b001, 1'b1), -1, -1);
        send(mk(16'h0ABD, 2'd2, 5'd8, 3'b000, 32'h0, 10'd6, 5'd3, 3'b000, 1'b0), -1, -1);
        send(mk(16'h0ABE, 2'd2, 5'd8, 3'b010, 32'h0, 10'd6, 5'd3, 3'b111, 1'b0), -1, -1);
        do_reset();
        chk(err_pin == 1'b0, "R6 cleared by reset", 32'(err_pin), 32'd0);
        send(mk(16'h0ABF, 2'd0, 5'd1, 3'b000, 32'h0, 10'd7, 5'd4, 3'b000, 1'b0), -1, -1);
        send(mk(16'h0AC0, 2'd0, 5'd1, 3'b000, 32'h10, 10'd7, 5'd4, 3'b000, 1'b0), -1, -1);

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule